// File: doc/BRIEF.md
# Mode register access request controller

This block sits inside a DRAM memory controller and turns one software-programmed control word into a series of mode register access requests, one for each selected rank. Software uses an APB slave port to program a mode register number, a mask of target ranks and a read/write type. It then sets a trigger bit in a separate bus write. The controller walks through the enabled ranks from the lowest index to the highest. For each one it presents a request on a valid/ready command port and holds it until it is accepted. When the last request has been accepted, the trigger bit clears on its own.

A status word reports whether the controller is busy and holds a sticky error flag. The error flag is set when a trigger is refused, either because the memory is in a state where such accesses are forbidden or because no rank is selected. In the low-power DRAM mode the register number comes from a side input rather than from the address field, and the type bit selects a read. In every other mode each request is a write.

The sequencer has three states. SQ_IDLE waits for an accepted trigger. SQ_ISSUE drives a request for the lowest rank still pending. SQ_FINISH lasts one cycle and releases the trigger. The transitions are: SQ_IDLE to SQ_ISSUE when a trigger is accepted. SQ_ISSUE stays in SQ_ISSUE while further ranks remain after a handshake, or while the port is stalled. SQ_ISSUE goes to SQ_FINISH on the handshake of the last pending rank. SQ_FINISH goes to SQ_IDLE unconditionally.

Top module: `mrac_ctrl`

## Requirements
- R1: After reset the control word (byte offset 0x0) reads 0x00000010 and the status word (byte offset 0x4) reads 0, and no request is presented.
- R2: Control word layout: bit 31 trigger (reads 1 exactly while an operation runs), bits 15:12 register number (0000 to 0111 name MR0 to MR7), bits 7:4 rank mask (bit 4+i enables rank i), bit 0 type (0 write, 1 read); all other bits read 0. An idle write with bit 31 = 0 loads the three fields.
- R3: An idle write with bit 31 = 1, while op_state is 00 (normal) and the stored rank mask is nonzero, starts an operation using the previously stored fields; the other bits of that write are discarded.
- R4: An operation issues exactly one request per set mask bit, in ascending rank order, with cmd_rank equal to the rank index.
- R5: A request stays asserted with unchanged cmd_rank, cmd_addr and cmd_read until cmd_ready is seen high.
- R6: With lpddr_mode = 0, cmd_addr is the stored register number zero-extended; with lpddr_mode = 1, it is lp_mr_addr. Both are sampled when the trigger is accepted.
- R7: cmd_read equals the stored type bit when lpddr_mode = 1 and is 0 otherwise, sampled when the trigger is accepted.
- R8: After the last handshake the trigger bit and the status busy bit (bit 0) clear without any software action.
- R9: A trigger written while op_state is 01 (init), 10 (deep power-down) or 11 (maximum power saving), or while the rank mask is zero, issues no request, leaves the trigger at 0 and sets the sticky error bit (status bit 1).
- R10: Writing status bit 1 as 1 clears the error bit; writing it as 0 leaves the bit unchanged.
- R11: While an operation runs, writes to the control word are ignored: neither fields nor trigger change and no second operation follows.
- R12: Writing 0 to the trigger bit while idle starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address (0x0 control, 0x4 status) |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| op_state | input | 2 | Memory operating state: 00 normal, 01 init, 10 deep power-down, 11 maximum power saving |
| lpddr_mode | input | 1 | Low-power DRAM mode select |
| lp_mr_addr | input | MRA_W | Register number used in low-power mode |
| cmd_valid | output | 1 | Request valid |
| cmd_ready | input | 1 | Request accepted |
| cmd_rank | output | RIDX_W | Target rank index |
| cmd_addr | output | MRA_W | Mode register number |
| cmd_read | output | 1 | 1 for read, 0 for write |

## Verification
The hardest case to reach from the ports is a bus write that lands while an operation is still in flight. Request acceptance is normally quick, so the trigger is back to 0 before a second APB transfer can finish. The bench therefore holds cmd_ready low, which freezes the sequencer in SQ_ISSUE. While it is frozen, the bench reads the trigger and busy bits and rewrites both the fields and the trigger. It then releases the port and counts the requests that follow. The stall-and-hold rule is exercised by a recurring ready pattern that drops low during the sweep of all sixteen masks in both modes.

// File: rtl/mrac_pkg.sv
package mrac_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ISSUE  = 2'd1,
        SQ_FINISH = 2'd2
    } seq_state_t;

    localparam logic [1:0] OPST_NORMAL = 2'b00;

    localparam int TRIG_BIT  = 31;
    localparam int MRA_LSB   = 12;
    localparam int MRA_FLD_W = 4;
    localparam int RANK_LSB  = 4;
    localparam int TYPE_BIT  = 0;
    localparam int BUSY_BIT  = 0;
    localparam int ERR_BIT   = 1;
endpackage

// File: rtl/mrac_rank_pick.sv
module mrac_rank_pick #(
    parameter int NRANK  = 4,
    parameter int RIDX_W = 2
) (
    input  logic [NRANK-1:0]  pend,
    output logic [NRANK-1:0]  first_oh,
    output logic [RIDX_W-1:0] idx,
    output logic              last
);
    for (genvar i = 0; i < NRANK; i++) begin : g_first
        if (i == 0) begin : g_lsb
            assign first_oh[i] = pend[i];
        end else begin : g_upper
            assign first_oh[i] = pend[i] & ~(|pend[i-1:0]);
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NRANK; i++) begin
            if (first_oh[i]) idx = RIDX_W'(i);
        end
    end

    assign last = ((pend & ~first_oh) == '0);
endmodule

// File: rtl/mrac_apb_regs.sv
module mrac_apb_regs
    import mrac_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NRANK  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    input  logic [1:0]           op_state,
    input  logic                 busy,
    output logic                 start,
    output logic [MRA_FLD_W-1:0] mr_addr,
    output logic [NRANK-1:0]     rank_mask,
    output logic                 mr_type
);
    logic [1:0] reg_sel;
    logic       wr_en, wr_ctrl, wr_stat, trig_req, allowed, err_q;
    logic       unused_bits;

    assign reg_sel  = paddr[3:2];
    assign wr_en    = psel && penable && pwrite;
    assign wr_ctrl  = wr_en && (reg_sel == 2'd0);
    assign wr_stat  = wr_en && (reg_sel == 2'd1);
    assign trig_req = wr_ctrl && !busy && pwdata[TRIG_BIT];
    assign allowed  = (op_state == OPST_NORMAL) && (|rank_mask);
    assign start    = trig_req && allowed;
    assign unused_bits = ^{paddr, pwdata};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr_addr   <= '0;
            rank_mask <= NRANK'(1);
            mr_type   <= 1'b0;
        end else if (wr_ctrl && !busy && !pwdata[TRIG_BIT]) begin
            mr_addr   <= pwdata[MRA_LSB +: MRA_FLD_W];
            rank_mask <= pwdata[RANK_LSB +: NRANK];
            mr_type   <= pwdata[TYPE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (trig_req && !allowed) begin
            err_q <= 1'b1;
        end else if (wr_stat && pwdata[ERR_BIT]) begin
            err_q <= 1'b0;
        end
    end

    always_comb begin
        prdata = '0;
        unique case (reg_sel)
            2'd0: begin
                prdata[TRIG_BIT]                = busy;
                prdata[MRA_LSB +: MRA_FLD_W]    = mr_addr;
                prdata[RANK_LSB +: NRANK]       = rank_mask;
                prdata[TYPE_BIT]                = mr_type;
            end
            2'd1: begin
                prdata[BUSY_BIT] = busy;
                prdata[ERR_BIT]  = err_q;
            end
            default: prdata = '0;
        endcase
    end

    // R9: a refused trigger raises the error flag and does not start work
    p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_req && !allowed) |=> (err_q && !busy));

    // R10: the error flag only falls on a clearing status write
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr_stat && pwdata[ERR_BIT])) |=> err_q);

    // R11: fields frozen while an operation runs
    p_fields_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mr_addr) && $stable(rank_mask) && $stable(mr_type)));

    // R3: an accepted trigger makes the sequencer busy
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/mrac_seq.sv
module mrac_seq
    import mrac_pkg::*;
#(
    parameter int NRANK  = 4,
    parameter int RIDX_W = 2,
    parameter int MRA_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NRANK-1:0]     rank_mask,
    input  logic [MRA_FLD_W-1:0] mr_addr,
    input  logic                 mr_type,
    input  logic                 lpddr_mode,
    input  logic [MRA_W-1:0]     lp_mr_addr,
    input  logic                 cmd_ready,
    output logic                 busy,
    output logic                 cmd_valid,
    output logic [RIDX_W-1:0]    cmd_rank,
    output logic [MRA_W-1:0]     cmd_addr,
    output logic                 cmd_read
);
    seq_state_t          state_q, state_d;
    logic [NRANK-1:0]    pend_q, first_oh;
    logic [RIDX_W-1:0]   pick_idx;
    logic                pick_last;
    logic [MRA_W-1:0]    addr_q;
    logic                read_q;

    mrac_rank_pick #(.NRANK(NRANK), .RIDX_W(RIDX_W)) u_pick (
        .pend     (pend_q),
        .first_oh (first_oh),
        .idx      (pick_idx),
        .last     (pick_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (start) state_d = SQ_ISSUE;
            SQ_ISSUE:  if (cmd_ready && pick_last) state_d = SQ_FINISH;
            SQ_FINISH: state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != SQ_IDLE);
        cmd_valid = (state_q == SQ_ISSUE);
        cmd_rank  = pick_idx;
        cmd_addr  = addr_q;
        cmd_read  = read_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            addr_q <= '0;
            read_q <= 1'b0;
        end else if (state_q == SQ_IDLE && start) begin
            pend_q <= rank_mask;
            addr_q <= lpddr_mode ? lp_mr_addr : MRA_W'(mr_addr);
            read_q <= lpddr_mode && mr_type;
        end else if (state_q == SQ_ISSUE && cmd_ready) begin
            pend_q <= pend_q & ~first_oh;
        end
    end

    // R5: a stalled request holds its content
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
        (cmd_valid && $stable(cmd_rank) && $stable(cmd_addr) && $stable(cmd_read)));

    // R4: ranks go out in strictly ascending order within one operation
    p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!cmd_valid || (cmd_rank > $past(cmd_rank))));

    // R8: the closing state returns the controller to idle
    p_finish_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_FINISH) |=> !busy);

    // R4: an issuing state always has a rank left to serve
    p_issue_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones(first_oh) == 1));
endmodule

// File: rtl/mrac_ctrl.sv
module mrac_ctrl
    import mrac_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NRANK  = 4,
    parameter int MRA_W  = 8,
    localparam int RIDX_W = (NRANK > 1) ? $clog2(NRANK) : 1
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic [1:0]        op_state,
    input  logic              lpddr_mode,
    input  logic [MRA_W-1:0]  lp_mr_addr,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [RIDX_W-1:0] cmd_rank,
    output logic [MRA_W-1:0]  cmd_addr,
    output logic              cmd_read
);
    logic                 busy, start, mr_type;
    logic [MRA_FLD_W-1:0] mr_addr;
    logic [NRANK-1:0]     rank_mask;

    assign pready = 1'b1;

    mrac_apb_regs #(.ADDR_W(ADDR_W), .NRANK(NRANK)) u_regs (
        .clk       (pclk),
        .rst_n     (presetn),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .op_state  (op_state),
        .busy      (busy),
        .start     (start),
        .mr_addr   (mr_addr),
        .rank_mask (rank_mask),
        .mr_type   (mr_type)
    );

    mrac_seq #(.NRANK(NRANK), .RIDX_W(RIDX_W), .MRA_W(MRA_W)) u_seq (
        .clk        (pclk),
        .rst_n      (presetn),
        .start      (start),
        .rank_mask  (rank_mask),
        .mr_addr    (mr_addr),
        .mr_type    (mr_type),
        .lpddr_mode (lpddr_mode),
        .lp_mr_addr (lp_mr_addr),
        .cmd_ready  (cmd_ready),
        .busy       (busy),
        .cmd_valid  (cmd_valid),
        .cmd_rank   (cmd_rank),
        .cmd_addr   (cmd_addr),
        .cmd_read   (cmd_read)
    );
endmodule

// File: tb/mrac_ctrl_bench.sv
`timescale 1ns/1ps
module mrac_ctrl_bench;
    logic        clk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [1:0]  op_state = 2'b00;
    logic        lpddr_mode = 1'b0;
    logic [7:0]  lp_mr_addr = '0;
    logic        cmd_valid, cmd_ready = 1'b0, cmd_read;
    logic [1:0]  cmd_rank;
    logic [7:0]  cmd_addr;

    int nchk = 0, nerr = 0, rcnt = 0, hs_n = 0;
    bit hold_ready = 1'b0, done = 1'b0, pv = 1'b0;
    logic [1:0] pv_rank;
    logic [7:0] pv_addr;
    logic [1:0] log_rank [16];
    logic [7:0] log_addr [16];
    logic       log_read [16];

    always #5 clk = ~clk;

    mrac_ctrl u_mrac_ctrl (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .op_state(op_state), .lpddr_mode(lpddr_mode), .lp_mr_addr(lp_mr_addr),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rank(cmd_rank),
        .cmd_addr(cmd_addr), .cmd_read(cmd_read)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // responder and handshake monitor, away from the rising edge
    always @(negedge clk) begin
        rcnt++;
        cmd_ready = hold_ready ? 1'b0 : (((rcnt * 5) + 3) % 4) != 1;
        #1;
        if (pv) chk("R5 hold", {22'd0, cmd_valid, cmd_rank, cmd_addr}, {22'd0, 1'b1, pv_rank, pv_addr});
        if (cmd_valid && cmd_ready) begin
            if (hs_n < 16) begin
                log_rank[hs_n] = cmd_rank;
                log_addr[hs_n] = cmd_addr;
                log_read[hs_n] = cmd_read;
            end
            hs_n++;
        end
        pv = cmd_valid && !cmd_ready;
        pv_rank = cmd_rank;
        pv_addr = cmd_addr;
    end

    task automatic apb_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; #2; d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        s = 32'h1;
        for (int i = 0; i < 100 && s[0]; i++) apb_rd(4'h4, s);
        chk("R8 busy clears", {31'd0, s[0]}, 32'd0);
    endtask

    task automatic run_op(input logic [3:0] m, input logic [3:0] a, input logic t,
                          input logic lp, input logic [7:0] la);
        logic [31:0] r;
        int k;
        lpddr_mode = lp; lp_mr_addr = la;
        apb_wr(4'h0, {16'd0, a, 4'd0, m, 3'd0, t});
        hs_n = 0;
        apb_wr(4'h0, 32'h8000_0000);
        wait_idle();
        chk("R4 request count", hs_n, $countones(m));
        k = 0;
        for (int i = 0; i < 4; i++) begin
            if (m[i] && k < hs_n) begin
                chk("R4 rank order", {30'd0, log_rank[k]}, i);
                chk("R6 address", {24'd0, log_addr[k]}, lp ? {24'd0, la} : {28'd0, a});
                chk("R7 type", {31'd0, log_read[k]}, {31'd0, lp & t});
                k++;
            end
        end
        apb_rd(4'h0, r);
        chk("R2 readback after op", r, {16'd0, a, 4'd0, m, 3'd0, t});
        apb_rd(4'h4, r);
        chk("R9 error for empty mask", {31'd0, r[1]}, {31'd0, (m == 0)});
        if (r[1]) apb_wr(4'h4, 32'h2);
    endtask

    initial begin
        logic [31:0] r;
        int h;
        repeat (3) @(negedge clk);
        presetn = 1'b1;
        // R1 reset values
        apb_rd(4'h0, r); chk("R1 control reset", r, 32'h0000_0010);
        apb_rd(4'h4, r); chk("R1 status reset", r, 32'h0);
        chk("R1 no request", {31'd0, cmd_valid}, 32'd0);

        // R12: trigger written as 0 starts nothing
        hs_n = 0;
        apb_wr(4'h0, 32'h0000_5030);
        repeat (10) @(negedge clk);
        chk("R12 no request", hs_n, 0);
        apb_rd(4'h0, r); chk("R2 fields load", r, 32'h0000_5030);

        // R3: fields in the trigger write are discarded
        apb_wr(4'h0, 32'h0000_3020);
        hs_n = 0;
        apb_wr(4'h0, 32'h8000_F0F1);
        wait_idle();
        chk("R3 one request", hs_n, 1);
        chk("R3 stored rank used", {30'd0, log_rank[0]}, 1);
        chk("R3 stored address used", {24'd0, log_addr[0]}, 3);
        apb_rd(4'h0, r); chk("R3 fields kept", r, 32'h0000_3020);

        // sweep of every mask, both modes, both types
        for (int m = 0; m < 16; m++)
            for (int lp = 0; lp < 2; lp++)
                for (int t = 0; t < 2; t++)
                    run_op(4'(m), 4'((m + 3 * t) % 8), 1'(t), 1'(lp), 8'(8'hA0 + m));
        lpddr_mode = 0;

        // R9: refused in each disallowed operating state
        apb_wr(4'h0, 32'h0000_20F0);
        for (int s = 1; s < 4; s++) begin
            op_state = 2'(s);
            hs_n = 0;
            apb_wr(4'h0, 32'h8000_0000);
            repeat (8) @(negedge clk);
            chk("R9 no request when blocked", hs_n, 0);
            apb_rd(4'h0, r); chk("R9 trigger stays 0", {31'd0, r[31]}, 32'd0);
            apb_rd(4'h4, r); chk("R9 error set", r, 32'h2);
            apb_wr(4'h4, 32'h0);
            apb_rd(4'h4, r); chk("R10 write 0 keeps error", r, 32'h2);
            apb_wr(4'h4, 32'h2);
            apb_rd(4'h4, r); chk("R10 error cleared", r, 32'h0);
        end
        op_state = 2'b00;

        // R11: writes during a stalled operation
        hold_ready = 1'b1;
        apb_wr(4'h0, 32'h0000_4090);
        hs_n = 0;
        apb_wr(4'h0, 32'h8000_0000);
        apb_rd(4'h0, r); chk("R8 trigger reads 1 while running", r, 32'h8000_4090);
        apb_rd(4'h4, r); chk("R8 busy while running", r, 32'h1);
        apb_wr(4'h0, 32'h0000_7061);
        apb_wr(4'h0, 32'h8000_0000);
        apb_rd(4'h0, r); chk("R11 fields ignored while busy", r, 32'h8000_4090);
        hold_ready = 1'b0;
        wait_idle();
        h = hs_n;
        repeat (10) @(negedge clk);
        chk("R11 no second operation", hs_n, 2);
        chk("R11 count stable", hs_n, h);
        apb_rd(4'h0, r); chk("R8 trigger cleared", r, 32'h0000_4090);
        apb_rd(4'h4, r); chk("R11 no error", r, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule